// File: doc/BRIEF.md
# CAN Message Mailbox Bank

This block holds fifteen message slots between a host processor and a CAN protocol engine. The host programs each slot through a small register port. Each slot has an enable, a direction, an 11-bit identifier, an acceptance mask, a data length, eight data bytes and two interrupt enables. Slots 1 to 14 can be configured for transmit or for receive. Slot 15 is receive-only and acts as the catch-all. It is double buffered: the engine can land a second frame in a shadow copy while the host is still reading the first.

Toward the engine, the bank offers one pending transmit slot at a time. The slot chosen is always the lowest-numbered pending slot; identifier value plays no part in the choice. When the engine reports a completed transmission, that slot's request drops and the next pending slot appears on the following cycle. Each frame the engine delivers goes to the lowest-numbered enabled receive slot whose identifier matches under its mask. A frame that matches none of them goes to slot 15.

Top module: `can_mailbox_bank`

## Requirements
- R1: A host write with `cfg_sel` 1, 2, 3, 4 or 5 stores the identifier, mask, length, data bits 31:0 or data bits 63:32 of slot `cfg_slot` (numbered 1..15). Reading the same slot and select returns the stored value. With select 0, control bits are written: bit0 enable, bit1 direction (1 = transmit, always 0 for slot 15), bit2 receive interrupt enable, bit3 transmit interrupt enable.
- R2: A received frame is accepted by slot k (1..14) only when slot k is enabled, set to receive, and `((rx_id ^ id) & mask) == 0`. A mask bit of 0 is don't-care. An accepted frame stores its identifier, length and data in the slot.
- R3: When several slots accept a frame, the lowest-numbered one takes it. When none accepts it, slot 15 takes it.
- R4: A frame that arrives for a slot whose new-data flag (status bit5) is still set overwrites the slot and sets the sticky lost flag (status bit6). Command bit2 (select 6) releases the slot. Command bit4 clears the lost and overrun flags.
- R5: `tx_valid` is high when any slot has a transmit request (status bit4). `tx_slot`, `tx_id`, `tx_dlc` and `tx_data` then show the lowest-numbered requesting slot, whatever the identifiers are. Command bit0 sets a request.
- R6: A `tx_done` pulse naming slot k clears that slot's request at the clock edge. The next requesting slot is shown from the following cycle.
- R7: A slot's interrupt flag (`irq_pend` bit k-1, status bit7) sets when a frame is stored into the slot with the receive enable set, or when its transmission completes with the transmit enable set. Command bit3 clears it. `irq` is the OR of all flags.
- R8: Slot 15 holds two frames in arrival order. Reads show the older frame, and status bit9 reports that the shadow copy is full. A release moves the shadow frame forward, or empties the slot when no shadow frame is held.
- R9: A frame for slot 15 that arrives while both of its buffers are full is dropped and sets the overrun flag (status bit8). The two stored frames are kept.
- R10: Command bit1 withdraws a transmit request. A request command to a slot set to receive has no effect.
- R11: After reset no slot is enabled, requesting, full or flagged, and `tx_valid` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_slot | input | SW | Slot written, 1..NSLOT |
| cfg_sel | input | 3 | Field select: 0 control, 1 id, 2 mask, 3 length, 4 data low, 5 data high, 6 command |
| cfg_wdata | input | 32 | Write data |
| rd_slot | input | SW | Slot read |
| rd_sel | input | 3 | Field read (0 gives status) |
| rd_data | output | 32 | Read data |
| tx_valid | output | 1 | A transmit slot is offered |
| tx_slot | output | SW | Offered slot number |
| tx_id | output | IDW | Offered identifier |
| tx_dlc | output | 4 | Offered length |
| tx_data | output | 64 | Offered data, byte 0 in bits 7:0 |
| tx_done | input | 1 | Engine reports a sent frame |
| tx_done_slot | input | SW | Slot that was sent |
| rx_valid | input | 1 | Engine delivers a received frame |
| rx_id | input | IDW | Received identifier |
| rx_dlc | input | 4 | Received length |
| rx_data | input | 64 | Received data |
| irq | output | 1 | Any slot interrupt flag set |
| irq_pend | output | NSLOT | Per-slot interrupt flags |

## Verification
The assertions assume that `tx_done` names only a slot that was requesting transmission. They also assume that a receive pulse lasts a single cycle per frame, so one frame is never counted twice by the overrun and shadow checks. The bench drives every input at the falling edge and holds each strobe for exactly one cycle. It reports a completion only for the slot currently shown on `tx_slot`, and it never combines a host command with a frame delivery in the same cycle.

// File: rtl/can_mailbox_bank.sv
module can_mailbox_bank #(
  parameter int NSLOT = 15,
  parameter int IDW   = 11,
  parameter int SW    = $clog2(NSLOT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [SW-1:0]  cfg_slot,
  input  logic [2:0]     cfg_sel,
  input  logic [31:0]    cfg_wdata,
  input  logic [SW-1:0]  rd_slot,
  input  logic [2:0]     rd_sel,
  output logic [31:0]    rd_data,
  output logic           tx_valid,
  output logic [SW-1:0]  tx_slot,
  output logic [IDW-1:0] tx_id,
  output logic [3:0]     tx_dlc,
  output logic [63:0]    tx_data,
  input  logic           tx_done,
  input  logic [SW-1:0]  tx_done_slot,
  input  logic           rx_valid,
  input  logic [IDW-1:0] rx_id,
  input  logic [3:0]     rx_dlc,
  input  logic [63:0]    rx_data,
  output logic           irq,
  output logic [NSLOT-1:0] irq_pend
);
  localparam logic [SW-1:0] LAST = SW'(NSLOT - 1);

  logic [NSLOT-1:0] en_q, dir_q, rxie_q, txie_q, txreq_q, nd_q, lost_q, irq_q;
  logic [IDW-1:0]   id_q   [NSLOT];
  logic [IDW-1:0]   mask_q [NSLOT];
  logic [3:0]       dlc_q  [NSLOT];
  logic [63:0]      dat_q  [NSLOT];
  logic [IDW-1:0]   sh_id;
  logic [3:0]       sh_dlc;
  logic [63:0]      sh_dat;
  logic             sh_full, ovr_q;

  wire wr_ok   = cfg_we && cfg_slot != '0 && cfg_slot <= SW'(NSLOT);
  wire [SW-1:0] wi = cfg_slot - 1'b1;
  wire cmd     = wr_ok && cfg_sel == 3'd6;
  wire rel15   = cmd && cfg_wdata[2] && wi == LAST;
  wire done_ok = tx_done && tx_done_slot != '0 && tx_done_slot <= SW'(NSLOT);
  wire [SW-1:0] di = tx_done_slot - 1'b1;
  wire [SW-1:0] ri = rd_slot - 1'b1;

  logic          rx_hit;
  logic [SW-1:0] rx_tgt, tx_idx;
  always_comb begin
    rx_hit = 1'b0;
    rx_tgt = LAST;
    for (int i = NSLOT - 2; i >= 0; i--)
      if (en_q[i] && !dir_q[i] && ((rx_id ^ id_q[i]) & mask_q[i]) == '0) begin
        rx_hit = 1'b1;
        rx_tgt = SW'(i);
      end
    tx_idx = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (txreq_q[i]) tx_idx = SW'(i);
  end
  wire rx15 = rx_valid && !rx_hit;

  assign tx_valid = |txreq_q;
  assign tx_slot  = tx_idx + 1'b1;
  assign tx_id    = id_q[tx_idx];
  assign tx_dlc   = dlc_q[tx_idx];
  assign tx_data  = dat_q[tx_idx];
  assign irq_pend = irq_q;
  assign irq      = |irq_q;

  always_comb begin
    rd_data = '0;
    if (rd_slot != '0 && rd_slot <= SW'(NSLOT))
      case (rd_sel)
        3'd0: rd_data = {22'd0, (ri == LAST) && sh_full, (ri == LAST) && ovr_q,
                         irq_q[ri], lost_q[ri], nd_q[ri], txreq_q[ri],
                         txie_q[ri], rxie_q[ri], dir_q[ri], en_q[ri]};
        3'd1: rd_data = 32'(id_q[ri]);
        3'd2: rd_data = 32'(mask_q[ri]);
        3'd3: rd_data = 32'(dlc_q[ri]);
        3'd4: rd_data = dat_q[ri][31:0];
        3'd5: rd_data = dat_q[ri][63:32];
        default: rd_data = '0;
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {en_q, dir_q, rxie_q, txie_q, txreq_q, nd_q, lost_q, irq_q} <= '0;
      for (int i = 0; i < NSLOT; i++) begin
        id_q[i] <= '0; mask_q[i] <= '0; dlc_q[i] <= '0; dat_q[i] <= '0;
      end
      sh_id <= '0; sh_dlc <= '0; sh_dat <= '0; sh_full <= 1'b0; ovr_q <= 1'b0;
    end else begin
      if (wr_ok)
        case (cfg_sel)
          3'd0: begin
            en_q[wi]   <= cfg_wdata[0];
            dir_q[wi]  <= cfg_wdata[1] && wi != LAST;
            rxie_q[wi] <= cfg_wdata[2];
            txie_q[wi] <= cfg_wdata[3];
          end
          3'd1: id_q[wi]          <= cfg_wdata[IDW-1:0];
          3'd2: mask_q[wi]        <= cfg_wdata[IDW-1:0];
          3'd3: dlc_q[wi]         <= cfg_wdata[3:0];
          3'd4: dat_q[wi][31:0]   <= cfg_wdata;
          3'd5: dat_q[wi][63:32]  <= cfg_wdata;
          3'd6: begin
            if (cfg_wdata[0] && dir_q[wi]) txreq_q[wi] <= 1'b1;
            if (cfg_wdata[1]) txreq_q[wi] <= 1'b0;
            if (cfg_wdata[2] && wi != LAST) nd_q[wi] <= 1'b0;
            if (cfg_wdata[3]) irq_q[wi] <= 1'b0;
            if (cfg_wdata[4]) begin
              lost_q[wi] <= 1'b0;
              if (wi == LAST) ovr_q <= 1'b0;
            end
          end
          default: ;
        endcase

      if (done_ok) begin
        txreq_q[di] <= 1'b0;
        if (txie_q[di]) irq_q[di] <= 1'b1;
      end

      if (rx_valid && rx_hit) begin
        id_q[rx_tgt]  <= rx_id;
        dlc_q[rx_tgt] <= rx_dlc;
        dat_q[rx_tgt] <= rx_data;
        nd_q[rx_tgt]  <= 1'b1;
        if (nd_q[rx_tgt]) lost_q[rx_tgt] <= 1'b1;
        if (rxie_q[rx_tgt]) irq_q[rx_tgt] <= 1'b1;
      end

      if (rel15 && sh_full) begin
        id_q[LAST] <= sh_id; dlc_q[LAST] <= sh_dlc; dat_q[LAST] <= sh_dat;
        if (rx15) begin
          sh_id <= rx_id; sh_dlc <= rx_dlc; sh_dat <= rx_data;
        end else sh_full <= 1'b0;
      end else if (rel15 || (rx15 && !nd_q[LAST])) begin
        if (rx15) begin
          id_q[LAST] <= rx_id; dlc_q[LAST] <= rx_dlc; dat_q[LAST] <= rx_data;
        end
        nd_q[LAST] <= rx15;
      end else if (rx15 && !sh_full) begin
        sh_id <= rx_id; sh_dlc <= rx_dlc; sh_dat <= rx_data; sh_full <= 1'b1;
      end else if (rx15) ovr_q <= 1'b1;

      if (rx15 && rxie_q[LAST] && !(nd_q[LAST] && sh_full && !rel15))
        irq_q[LAST] <= 1'b1;
    end
  end

  p_tx_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> txreq_q[tx_slot - 1'b1]);
  p_tx_lowest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (txreq_q & ((NSLOT'(1) << (tx_slot - 1'b1)) - 1'b1)) == '0);
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> !txreq_q[$past(di)]);
  p_ovr_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(rx15 && nd_q[LAST] && sh_full && !rel15));
  p_shadow_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sh_full |-> nd_q[LAST]);
endmodule

// File: tb/can_mailbox_bank_test.sv
module can_mailbox_bank_test;
  localparam int SW = 4;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [SW-1:0] cfg_slot = 0; logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic [SW-1:0] rd_slot = 0; logic [2:0] rd_sel = 0; logic [31:0] rd_data;
  logic tx_valid; logic [SW-1:0] tx_slot; logic [10:0] tx_id;
  logic [3:0] tx_dlc; logic [63:0] tx_data;
  logic tx_done = 0; logic [SW-1:0] tx_done_slot = 0;
  logic rx_valid = 0; logic [10:0] rx_id = 0; logic [3:0] rx_dlc = 0;
  logic [63:0] rx_data = 0;
  logic irq; logic [14:0] irq_pend;
  int nchk = 0, nerr = 0;
  logic [31:0] v;

  can_mailbox_bank uut (.*);

  always #5 clk = ~clk;

  localparam logic [14:0] VEC [6] = '{
    {11'h100, 4'd1}, {11'h101, 4'd15}, {11'h2AB, 4'd2},
    {11'h205, 4'd2}, {11'h300, 4'd15}, {11'h1FF, 4'd15}};

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int s, input int sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_slot = SW'(s); cfg_sel = 3'(sel); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rxf(input logic [10:0] id, input logic [3:0] n, input logic [63:0] d);
    @(negedge clk);
    rx_valid = 1; rx_id = id; rx_dlc = n; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic tdone(input int s);
    @(negedge clk);
    tx_done = 1; tx_done_slot = SW'(s);
    @(negedge clk);
    tx_done = 0;
  endtask

  task automatic rd(input int s, input int sel, output logic [31:0] o);
    rd_slot = SW'(s); rd_sel = 3'(sel);
    #1 o = rd_data;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 tx_valid", tx_valid, 0);
    chk("R11 irq", irq, 0);
    rd(15, 0, v); chk("R11 status15", v, 0);

    wr(1, 0, 32'h5); wr(1, 1, 32'h100); wr(1, 2, 32'h7FF);
    wr(2, 0, 32'h1); wr(2, 1, 32'h200); wr(2, 2, 32'h700);
    wr(3, 0, 32'h1); wr(3, 1, 32'h200); wr(3, 2, 32'h7F0);
    wr(4, 0, 32'hB); wr(4, 1, 32'h300); wr(4, 2, 32'h7FF);
    wr(5, 0, 32'h0); wr(5, 1, 32'h300); wr(5, 2, 32'h7FF);
    wr(4, 3, 32'h5); wr(4, 4, 32'hCAFEF00D); wr(4, 5, 32'h01234567);
    rd(2, 2, v); chk("R1 mask readback", v, 32'h700);
    rd(4, 3, v); chk("R1 dlc readback", v, 32'h5);
    rd(4, 5, v); chk("R1 data hi readback", v, 32'h01234567);
    rd(4, 0, v); chk("R1 ctrl readback", v, 32'hB);

    foreach (VEC[k]) begin
      rxf(VEC[k][14:4], 4'd2, 64'(VEC[k][14:4]));
      rd(VEC[k][3:0], 1, v); chk("R2 R3 target id", v, 32'(VEC[k][14:4]));
      rd(VEC[k][3:0], 0, v); chk("R2 R3 new data", v[5], 1);
      rd(VEC[k][3:0], 4, v); chk("R2 data stored", v, 32'(VEC[k][14:4]));
      wr(VEC[k][3:0], 6, 32'h4);
    end
    rd(3, 0, v); chk("R3 slot3 untouched", v[5], 0);
    chk("R7 rx irq slot1", irq_pend[0], 1);
    chk("R7 no irq slot2", irq_pend[1], 0);
    wr(1, 6, 32'h8);
    chk("R7 irq cleared", irq, 0);

    wr(6, 0, 32'h3); wr(6, 1, 32'h001);
    wr(9, 0, 32'h3); wr(9, 1, 32'h050);
    wr(4, 1, 32'h700);
    wr(9, 6, 32'h1); wr(6, 6, 32'h1);
    chk("R5 offered slot6", tx_slot, 6);
    chk("R5 offered id", tx_id, 11'h001);
    wr(4, 6, 32'h1);
    chk("R5 index over id", tx_slot, 4);
    chk("R5 id slot4", tx_id, 11'h700);
    chk("R5 dlc slot4", tx_dlc, 4'd5);
    chk("R5 data slot4", tx_data, 64'h01234567CAFEF00D);
    tdone(4);
    chk("R6 next slot", tx_slot, 6);
    rd(4, 0, v); chk("R6 request cleared", v[4], 0);
    chk("R7 tx irq slot4", irq_pend[3], 1);
    tdone(6);
    chk("R6 next slot 9", tx_slot, 9);
    chk("R7 no tx irq slot6", irq_pend[5], 0);
    tdone(9);
    chk("R6 idle", tx_valid, 0);
    wr(6, 6, 32'h1); wr(6, 6, 32'h2);
    chk("R10 cancel", tx_valid, 0);
    wr(2, 6, 32'h1);
    chk("R10 rx slot request ignored", tx_valid, 0);
    rd(2, 0, v); chk("R10 no request bit", v[4], 0);
    wr(4, 6, 32'h8);

    rxf(11'h100, 4'd8, 64'h1111);
    rxf(11'h100, 4'd8, 64'h2222);
    rd(1, 0, v); chk("R4 lost set", v[6], 1);
    rd(1, 4, v); chk("R4 overwritten", v, 32'h2222);
    wr(1, 6, 32'h14);
    rd(1, 0, v); chk("R4 lost cleared", v[6:5], 0);

    wr(15, 0, 32'h4);
    rxf(11'h111, 4'd1, 64'hA);
    rxf(11'h122, 4'd1, 64'hB);
    rd(15, 0, v); chk("R8 shadow full", v[9], 1);
    chk("R7 slot15 irq", irq_pend[14], 1);
    rxf(11'h133, 4'd1, 64'hC);
    rd(15, 0, v); chk("R9 overrun", v[8], 1);
    rd(15, 1, v); chk("R8 R9 oldest kept", v, 32'h111);
    wr(15, 6, 32'h4);
    rd(15, 1, v); chk("R8 shadow moved", v, 32'h122);
    rd(15, 4, v); chk("R9 dropped frame absent", v, 32'hB);
    rd(15, 0, v); chk("R8 shadow empty", v[9], 0);
    wr(15, 6, 32'h4);
    rd(15, 0, v); chk("R8 slot empty", v[5], 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule